// File: doc/BRIEF.md
# Processor Idle and Wake Controller

This block governs the low-power idle state of a CPU core. When the instruction decoder executes the idle instruction, it raises `idle_req`. The controller then issues one program-counter advance strobe and drops the core clock enable. Interrupt-capable peripherals and all stored state keep running while the core sleeps. The controller latches interrupt requests into pending flags and watches them, together with the non-maskable request, for a reason to wake.

A maskable source wakes the core when its mask bit is set, whatever the global interrupt disable. The global disable only settles what happens after waking. When it is clear, the core vectors to the service routine of the winning source. When it is set, the core falls through to the instruction after idle, and the flag stays pending for later service. A non-maskable request always wakes the core and vectors at once. Leaving reset always produces a reset vector. A control bit chooses whether the external clock output runs or stops while the core sleeps.

Vector indices are encoded as follows: 0 is reset, 1 is the non-maskable source, and 2+k is maskable line k. Among maskable lines, a lower k has higher priority. The vector index is meaningful only while `vec_req` is high, and it reads 0 otherwise.

Top module: `idle_wake_ctrl`

## Requirements
- R1: A cycle with `rst` high leaves `core_en`=0, `pc_inc`=0, `vec_req`=0 and `clkout_en`=1, with all pending flags cleared. The first cycle after `rst` falls shows `core_en`=1 and a one-cycle `vec_req` with `vec_idx`=0.
- R2: While running, `idle_req` sampled high gives `core_en`=0 and `pc_inc`=1 on the next cycle. `pc_inc` lasts exactly one cycle per idle entry.
- R3: While idle, `idle_req` has no effect: no further `pc_inc`, and `core_en` stays 0 until a wake condition.
- R4: A maskable request whose `irq_mask` bit is 0 does not wake the core. Its pending flag is kept, and it wakes the core in the cycle after its mask bit becomes 1.
- R5: While idle with `gmask`=0, an unmasked request on line k sampled at a clock edge makes `core_en`=1 after that same edge. `vec_req`=1 and `vec_idx`=2+k appear in the same cycle.
- R6: While idle with `gmask`=1, an unmasked request wakes the core (`core_en`=1) without any `vec_req`. The flag stays pending.
- R7: `nmi` wakes the core regardless of `gmask` and `irq_mask`, and vectors with `vec_idx`=1 in the same cycle as the wake. In the running state it also vectors at once.
- R8: If several sources are pending, the non-maskable one is served first, then maskable lines in ascending index. Each vector takes one cycle and clears only the flag it served.
- R9: While idle, `clkout_en` equals the inverse of `clkout_off` sampled one edge earlier. While running, and in the cycle of waking, it is 1.
- R10: A request that arrives in the same cycle as `idle_req` still wakes the core. `core_en` is low for exactly one cycle, and the wake then follows R5 or R6.
- R11: While running with `gmask`=0, any pending unmasked flag produces a vector on the next cycle, including one left by an R6 wake. With `gmask`=1, no maskable vector is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also the reset wake source |
| idle_req | input | 1 | Decoder executes the idle instruction |
| irq_req | input | NUM_IRQ | Maskable interrupt request lines, latched as pending |
| irq_mask | input | NUM_IRQ | Per-line enable; 1 allows the line to wake and vector |
| gmask | input | 1 | Global interrupt disable; 1 suppresses maskable vectors |
| nmi | input | 1 | Non-maskable request, latched as pending |
| clkout_off | input | 1 | 1 stops the clock output while idle |
| core_en | output | 1 | Core clock enable |
| pc_inc | output | 1 | One-cycle program-counter advance on idle entry |
| vec_req | output | 1 | One-cycle vector request |
| vec_idx | output | VEC_W | Vector index: 0 reset, 1 NMI, 2+k line k |
| clkout_en | output | 1 | Clock output enable |

## Verification
On every cycle, the embedded properties check several things: the single-cycle program-counter strobe, the wake latency of one edge, the absence of a vector when waking under global disable, a held idle state without a wake reason, the registered tracking of the clock-output control while asleep, and the retention of unserved pending flags. Other behaviour depends on stimulus history, and only the bench scenarios can show it. This covers the vector index for each line and mask combination, the service order across several pending sources, a masked flag waking the core once unmasked, a late vector after a fall-through wake, and a request that coincides with idle entry.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_RUN  = 2'd1,
    ST_IDLE = 2'd2
  } iw_state_e;

  localparam int VEC_RST      = 0;
  localparam int VEC_NMI      = 1;
  localparam int VEC_IRQ_BASE = 2;

endpackage

// File: rtl/iw_pending.sv
module iw_pending #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_mask,
  input  logic               nmi,
  input  logic [NUM_IRQ-1:0] clr_irq,
  input  logic               clr_nmi,
  output logic [NUM_IRQ-1:0] ready,
  output logic               nmi_eff
);

  logic [NUM_IRQ-1:0] pend_q;
  logic               nmi_q;
  logic [NUM_IRQ-1:0] eff;

  // Raw requests count in the cycle they arrive, so no edge is lost.
  assign eff     = pend_q | irq_req;
  assign ready   = eff & irq_mask;
  assign nmi_eff = nmi_q | nmi;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      nmi_q  <= 1'b0;
    end else begin
      pend_q <= eff & ~clr_irq;
      nmi_q  <= nmi_eff & ~clr_nmi;
    end
  end

  // R6 / R4: a flag that is not served this cycle survives to the next
  pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (|(pend_q & ~clr_irq)) |=> ((pend_q & $past(pend_q & ~clr_irq)) == $past(pend_q & ~clr_irq)));

endmodule

// File: rtl/iw_prio.sv
module iw_prio #(
  parameter int NUM_IRQ = 8,
  localparam int IRQ_IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] ready,
  output logic               any,
  output logic [IRQ_IW-1:0]  idx,
  output logic [NUM_IRQ-1:0] grant
);

  // Lowest index wins; scan from the top so the last hit is the winner.
  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (ready[i]) begin
        idx   = IRQ_IW'(i);
        grant = NUM_IRQ'(1) << i;
      end
    end
  end

  assign any = |ready;

endmodule

// File: rtl/iw_fsm.sv
module iw_fsm
  import idle_wake_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 4,
  localparam int IRQ_IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               idle_req,
  input  logic               gmask,
  input  logic               clkout_off,
  input  logic               nmi_eff,
  input  logic               sel_any,
  input  logic [IRQ_IW-1:0]  sel_idx,
  input  logic [NUM_IRQ-1:0] sel_grant,
  output logic               core_en,
  output logic               pc_inc,
  output logic               vec_req,
  output logic [VEC_W-1:0]   vec_idx,
  output logic               clkout_en,
  output logic [NUM_IRQ-1:0] clr_irq,
  output logic               clr_nmi
);

  iw_state_e        st_q, st_n;
  logic             core_n, pc_n, vreq_n, clk_n, svc;
  logic [VEC_W-1:0] vidx_n;

  always_comb begin
    st_n    = st_q;
    core_n  = core_en;
    pc_n    = 1'b0;
    vreq_n  = 1'b0;
    vidx_n  = '0;
    clk_n   = clkout_en;
    clr_irq = '0;
    clr_nmi = 1'b0;
    svc     = 1'b0;
    case (st_q)
      ST_BOOT: begin
        st_n   = ST_RUN;
        core_n = 1'b1;
        clk_n  = 1'b1;
        vreq_n = 1'b1;
        vidx_n = VEC_W'(VEC_RST);
      end
      ST_RUN: begin
        clk_n = 1'b1;
        if (idle_req) begin
          st_n   = ST_IDLE;
          core_n = 1'b0;
          pc_n   = 1'b1;
          clk_n  = ~clkout_off;
        end else begin
          svc = 1'b1;
        end
      end
      ST_IDLE: begin
        clk_n = ~clkout_off;
        if (nmi_eff || sel_any) begin
          st_n   = ST_RUN;
          core_n = 1'b1;
          clk_n  = 1'b1;
          svc    = 1'b1;
        end
      end
      default: st_n = ST_BOOT;
    endcase
    if (svc) begin
      if (nmi_eff) begin
        vreq_n  = 1'b1;
        vidx_n  = VEC_W'(VEC_NMI);
        clr_nmi = 1'b1;
      end else if (!gmask && sel_any) begin
        vreq_n  = 1'b1;
        vidx_n  = VEC_W'(VEC_IRQ_BASE) + VEC_W'(sel_idx);
        clr_irq = sel_grant;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_BOOT;
      core_en   <= 1'b0;
      pc_inc    <= 1'b0;
      vec_req   <= 1'b0;
      vec_idx   <= '0;
      clkout_en <= 1'b1;
    end else begin
      st_q      <= st_n;
      core_en   <= core_n;
      pc_inc    <= pc_n;
      vec_req   <= vreq_n;
      vec_idx   <= vidx_n;
      clkout_en <= clk_n;
    end
  end

  // R2
  pc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pc_inc |=> !pc_inc);

  // R5
  wake_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && (nmi_eff || sel_any)) |=> core_en);

  // R6
  gmask_novec_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !nmi_eff && sel_any && gmask) |=> (core_en && !vec_req));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !nmi_eff && !sel_any) |=> (!core_en && !pc_inc));

  // R9
  clkout_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !nmi_eff && !sel_any) |=> (clkout_en == !$past(clkout_off)));

endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
  import idle_wake_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int VEC_W  = $clog2(NUM_IRQ + VEC_IRQ_BASE),
  localparam int IRQ_IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               idle_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_mask,
  input  logic               gmask,
  input  logic               nmi,
  input  logic               clkout_off,
  output logic               core_en,
  output logic               pc_inc,
  output logic               vec_req,
  output logic [VEC_W-1:0]   vec_idx,
  output logic               clkout_en
);

  logic [NUM_IRQ-1:0] ready, grant, clr_irq;
  logic [IRQ_IW-1:0]  sel_idx;
  logic               sel_any, nmi_eff, clr_nmi;

  iw_pending #(.NUM_IRQ(NUM_IRQ)) pend_i (
    .clk      (clk),
    .rst      (rst),
    .irq_req  (irq_req),
    .irq_mask (irq_mask),
    .nmi      (nmi),
    .clr_irq  (clr_irq),
    .clr_nmi  (clr_nmi),
    .ready    (ready),
    .nmi_eff  (nmi_eff)
  );

  iw_prio #(.NUM_IRQ(NUM_IRQ)) prio_i (
    .ready (ready),
    .any   (sel_any),
    .idx   (sel_idx),
    .grant (grant)
  );

  iw_fsm #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .idle_req   (idle_req),
    .gmask      (gmask),
    .clkout_off (clkout_off),
    .nmi_eff    (nmi_eff),
    .sel_any    (sel_any),
    .sel_idx    (sel_idx),
    .sel_grant  (grant),
    .core_en    (core_en),
    .pc_inc     (pc_inc),
    .vec_req    (vec_req),
    .vec_idx    (vec_idx),
    .clkout_en  (clkout_en),
    .clr_irq    (clr_irq),
    .clr_nmi    (clr_nmi)
  );

  // R7
  vec_when_run_chk: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> core_en);

endmodule

// File: tb/idle_wake_ctrl_tb.sv
`timescale 1ns/1ps
module idle_wake_ctrl_tb_top;

  localparam int N  = 4;
  localparam int VW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          idle_req = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic [N-1:0]  irq_mask = '0;
  logic          gmask = 1'b0;
  logic          nmi = 1'b0;
  logic          clkout_off = 1'b0;
  logic          core_en, pc_inc, vec_req, clkout_en;
  logic [VW-1:0] vec_idx;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  idle_wake_ctrl #(.NUM_IRQ(N)) dut_i (
    .clk(clk), .rst(rst), .idle_req(idle_req), .irq_req(irq_req),
    .irq_mask(irq_mask), .gmask(gmask), .nmi(nmi), .clkout_off(clkout_off),
    .core_en(core_en), .pc_inc(pc_inc), .vec_req(vec_req),
    .vec_idx(vec_idx), .clkout_en(clkout_en)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    idle_req = 0; irq_req = '0; nmi = 0;
    rst = 1; tick();
    rst = 0; tick();
  endtask

  task automatic enter_idle();
    idle_req = 1; tick(); idle_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    // R1 reset state and boot vector
    rst = 1; tick(); tick();
    chk("R1 core_en in reset", core_en, 0);
    chk("R1 vec_req in reset", vec_req, 0);
    chk("R1 pc_inc in reset", pc_inc, 0);
    chk("R1 clkout_en in reset", clkout_en, 1);
    rst = 0; tick();
    chk("R1 boot core_en", core_en, 1);
    chk("R1 boot vec_req", vec_req, 1);
    chk("R1 boot vec_idx", vec_idx, 0);
    tick();
    chk("R1 boot pulse single", vec_req, 0);

    // Sweep: global disable x mask pattern x request line
    for (int g = 0; g < 2; g++) begin
      for (int m = 0; m < (1 << N); m++) begin
        for (int k = 0; k < N; k++) begin
          do_reset();
          irq_mask = N'(m); gmask = g[0];
          enter_idle();
          chk("R2 core_en drops", core_en, 0);
          chk("R2 pc_inc strobe", pc_inc, 1);
          idle_req = 1; tick(); idle_req = 0;
          chk("R3 no second pc_inc", pc_inc, 0);
          chk("R3 stays asleep", core_en, 0);
          irq_req = N'(1) << k; tick(); irq_req = '0;
          if (((m >> k) & 1) == 1) begin
            chk("R5 wake in one edge", core_en, 1);
            chk("R5 R6 vector choice", vec_req, (g == 0) ? 1 : 0);
            if (g == 0) chk("R5 vector index", vec_idx, 2 + k);
            else begin
              tick();
              chk("R6 no vector while disabled", vec_req, 0);
              gmask = 0; tick();
              chk("R11 late vector", vec_req, 1);
              chk("R11 late index", vec_idx, 2 + k);
            end
            tick();
            chk("R8 flag cleared after service", vec_req, 0);
          end else begin
            chk("R4 masked no wake", core_en, 0);
            chk("R4 masked no vector", vec_req, 0);
            tick();
            chk("R4 still asleep", core_en, 0);
            irq_mask = N'(m | (1 << k)); tick();
            chk("R4 pending wakes once unmasked", core_en, 1);
            chk("R4 vector choice", vec_req, (g == 0) ? 1 : 0);
          end
        end
      end
    end

    // R8 service order sweep in the running state
    for (int p = 1; p < (1 << N); p++) begin
      do_reset();
      irq_mask = '1; gmask = 1;
      irq_req = N'(p); tick(); irq_req = '0;
      chk("R11 no vector when disabled", vec_req, 0);
      gmask = 0;
      for (int b = 0; b < N; b++) begin
        if (((p >> b) & 1) == 1) begin
          tick();
          chk("R8 ordered vector", vec_req, 1);
          chk("R8 ordered index", vec_idx, 2 + b);
        end
      end
      tick();
      chk("R8 queue drained", vec_req, 0);
    end

    // R7 NMI wakes regardless of masks, then beats maskable
    do_reset();
    irq_mask = '0; gmask = 1;
    enter_idle();
    nmi = 1; tick(); nmi = 0;
    chk("R7 nmi wake", core_en, 1);
    chk("R7 nmi vector", vec_req, 1);
    chk("R7 nmi index", vec_idx, 1);
    do_reset();
    irq_mask = '1; gmask = 0;
    enter_idle();
    nmi = 1; irq_req = 4'b0100; tick(); nmi = 0; irq_req = '0;
    chk("R8 nmi first", vec_idx, 1);
    tick();
    chk("R8 then line 2", vec_idx, 4);
    chk("R8 then line 2 req", vec_req, 1);
    tick();
    chk("R8 done", vec_req, 0);

    // R10 request coinciding with idle entry
    do_reset();
    irq_mask = '1; gmask = 0;
    idle_req = 1; irq_req = 4'b0010; tick(); idle_req = 0; irq_req = '0;
    chk("R10 enters idle", core_en, 0);
    chk("R10 pc strobe", pc_inc, 1);
    chk("R10 no early vector", vec_req, 0);
    tick();
    chk("R10 wakes next cycle", core_en, 1);
    chk("R10 vector index", vec_idx, 3);

    // R9 clock output control
    do_reset();
    irq_mask = '0; clkout_off = 1; tick();
    chk("R9 running clkout", clkout_en, 1);
    enter_idle();
    chk("R9 idle stopped", clkout_en, 0);
    clkout_off = 0; tick();
    chk("R9 idle running", clkout_en, 1);
    clkout_off = 1; tick();
    chk("R9 idle stopped again", clkout_en, 0);
    nmi = 1; tick(); nmi = 0;
    chk("R9 wake restores clkout", clkout_en, 1);

    // R1 reset from idle
    enter_idle();
    rst = 1; tick(); rst = 0; tick();
    chk("R1 reset from idle wakes", core_en, 1);
    chk("R1 reset vector index", vec_idx, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule